// File: doc/BRIEF.md
# Condition Code Flag Unit

This block produces the negative, zero, overflow and carry flags for an accumulator CPU that works on 8-bit and 16-bit data. The arithmetic itself happens somewhere else. The unit receives the two operands and the result that the datapath already computed, together with an operation class (add, subtract, test or shift) and a width select. It derives every flag from the sign bits of the operands and the result, so it never needs a carry chain out of an adder.

The flags are written into an 8-bit condition code register when an update enable is high. Flags that the operation does not define keep their old value. The upper four register bits are never written by this unit. The freshly computed flags are also available combinationally, so decode logic can use them in the same cycle.

Top module: `ccr_flag_unit`

## Requirements
- R1: A synchronous active-low reset loads the register with 0xD0. The bit layout from bit 7 down to bit 0 is S, X, H, I, N, Z, V, C, so the reset sets S, X and I and clears all others.
- R2: Add class (op_sel = 2'b00): C is the sign bit of (a&b)|(b&~r)|(a&~r), and V is the sign bit of (a&b&~r)|(~a&~b&r).
- R3: Subtract class (op_sel = 2'b01): C is the sign bit of (~a&b)|(b&r)|(~a&r), and V is the sign bit of (a&~b&~r)|(~a&b&r).
- R4: For every class, N is the sign bit of the result and Z is set exactly when the result is zero at the selected width. The sign bit is bit 7 when wide = 0 and bit 15 when wide = 1.
- R5: Test class (op_sel = 2'b10) clears V, takes N and Z from the result input, and leaves C in the register unchanged.
- R6: Shift class (op_sel = 2'b11) takes N and Z from the result, loads C from shift_c, and sets V to the new N XOR shift_c.
- R7: The register takes the new flags on the first rising clock edge at which upd_en is high. While upd_en is low the register holds its value.
- R8: Bits 7 to 4 of the register (S, X, H, I) are never changed by an update.
- R9: When wide = 0, bits 15 to 8 of op_a, op_b and op_r have no effect on either flags_nzvc or the register.
- R10: flags_nzvc presents the computed {N,Z,V,C} combinationally from the current inputs. Its bit 3 is N and its bit 0 is C. For the test class, bit 0 equals the register's current C.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_sel | input | 2 | Operation class: 00 add, 01 subtract, 10 test, 11 shift |
| wide | input | 1 | 1 selects 16-bit flags, 0 selects 8-bit flags |
| op_a | input | 16 | First operand |
| op_b | input | 16 | Second operand |
| op_r | input | 16 | Result of the operation (or the value under test) |
| shift_c | input | 1 | Carry out of the shifter |
| upd_en | input | 1 | Write the computed flags into the register |
| flags_nzvc | output | 4 | Combinational {N,Z,V,C} for the current inputs |
| ccr_q | output | 8 | Condition code register |

## Verification
The bench builds the unit with its default parameters: a 16-bit data width and an 8-bit narrow width. With these values both sign-bit positions used by real code are exercised. Random values in bits 15 to 8 during narrow operations show whether the high byte leaks into the narrow flags. Directed cases cover the 0x7F/0x80 and 0x7FFF/0x8000 overflow boundaries, wrap to zero, borrow, and a test operation while C is set. Random operations with upd_en toggling check that the register holds its value and that masking is correct.

// File: rtl/ccr_pkg.sv
// Shared types and constants for the condition code flag unit.
// Assumes an 8-bit register with the flag layout S X H I N Z V C (bit 7 down to bit 0).
package ccr_pkg;

    typedef enum logic [1:0] {
        CLS_ADD   = 2'b00,
        CLS_SUB   = 2'b01,
        CLS_TEST  = 2'b10,
        CLS_SHIFT = 2'b11
    } alu_class_e;

    localparam int CCR_W = 8;

    // Bit positions inside the register
    localparam int BIT_C = 0;
    localparam int BIT_V = 1;
    localparam int BIT_Z = 2;
    localparam int BIT_N = 3;

    // Width of the arithmetic flag field (N Z V C)
    localparam int NZVC_W = 4;

    localparam logic [CCR_W-1:0] CCR_RESET = 8'hD0;

endpackage

// File: rtl/ccr_flag_slice.sv
// Flag evaluation for a single data width W.
// Produces {N,Z,V,C} from the sign bits of the operands and the result.
// C for the test class is a placeholder; the caller masks it out.
// Assumes r is the already-computed result at width W.
module ccr_flag_slice #(
    parameter int W = 8
) (
    input  logic                    [W-1:0] a,
    input  logic                    [W-1:0] b,
    input  logic                    [W-1:0] r,
    input  ccr_pkg::alu_class_e             cls,
    input  logic                            shift_c,
    output logic [ccr_pkg::NZVC_W-1:0]      nzvc
);
    import ccr_pkg::*;

    localparam int MSB = W - 1;

    logic sa, sb, sr;
    logic n_f, z_f, v_f, c_f;
    logic unused_low;

    assign sa = a[MSB];
    assign sb = b[MSB];
    assign sr = r[MSB];

    // Only the sign bits of the operands contribute to the flags.
    assign unused_low = ^{a[MSB-1:0], b[MSB-1:0]};

    // Choose the flag equations for the operation class.
    always_comb begin
        n_f = sr;
        z_f = (r == '0);
        v_f = 1'b0;
        c_f = 1'b0;
        case (cls)
            CLS_ADD: begin
                c_f = (sa & sb) | (sb & ~sr) | (sa & ~sr);
                v_f = (sa & sb & ~sr) | (~sa & ~sb & sr);
            end
            CLS_SUB: begin
                c_f = (~sa & sb) | (sb & sr) | (~sa & sr);
                v_f = (sa & ~sb & ~sr) | (~sa & sb & sr);
            end
            CLS_TEST: begin
                c_f = 1'b0;
                v_f = 1'b0;
            end
            CLS_SHIFT: begin
                c_f = shift_c;
                v_f = sr ^ shift_c;
            end
            default: begin
                c_f = 1'b0;
                v_f = 1'b0;
            end
        endcase
    end

    // Pack the flags in register order.
    always_comb begin
        nzvc        = '0;
        nzvc[BIT_N] = n_f;
        nzvc[BIT_Z] = z_f;
        nzvc[BIT_V] = v_f;
        nzvc[BIT_C] = c_f;
    end

    // Check the overflow cases at the flag outputs.
    always_comb begin
        if (cls == CLS_ADD && sa == sb && sr != sa) begin
            p_add_signflip_v_r2: assert (nzvc[BIT_V]);
        end
        if (cls == CLS_SUB && sa == sb) begin
            p_sub_samesign_nov_r3: assert (!nzvc[BIT_V]);
        end
        if (cls == CLS_TEST) begin
            p_test_clears_v_r5: assert (!nzvc[BIT_V]);
        end
    end

endmodule

// File: rtl/ccr_width_select.sv
// Builds one flag slice per supported width and selects one with 'wide'.
// Also produces the write mask: the test class leaves C alone.
// Assumes NARROW_W < DATA_W; the narrow slice sees only the low bits.
module ccr_width_select #(
    parameter int DATA_W   = 16,
    parameter int NARROW_W = 8
) (
    input  logic                   [DATA_W-1:0] op_a,
    input  logic                   [DATA_W-1:0] op_b,
    input  logic                   [DATA_W-1:0] op_r,
    input  ccr_pkg::alu_class_e                 cls,
    input  logic                                wide,
    input  logic                                shift_c,
    output logic [ccr_pkg::NZVC_W-1:0]          flags,
    output logic [ccr_pkg::NZVC_W-1:0]          wr_mask
);
    import ccr_pkg::*;

    localparam int NUM_W = 2;

    logic [NZVC_W-1:0] slice_flags [NUM_W];

    // One slice per width; index 0 is narrow, index 1 is wide.
    for (genvar g = 0; g < NUM_W; g++) begin : g_width
        localparam int SW = (g == 0) ? NARROW_W : DATA_W;
        ccr_flag_slice #(.W(SW)) u_slice (
            .a       (op_a[SW-1:0]),
            .b       (op_b[SW-1:0]),
            .r       (op_r[SW-1:0]),
            .cls     (cls),
            .shift_c (shift_c),
            .nzvc    (slice_flags[g])
        );
    end

    // Choose the flags for the active width.
    always_comb begin
        flags = wide ? slice_flags[1] : slice_flags[0];
    end

    // Decide which flags the class is allowed to write.
    always_comb begin
        wr_mask = '1;
        if (cls == CLS_TEST) begin
            wr_mask[BIT_C] = 1'b0;
        end
    end

    // Check that the selected flags are consistent with the result's sign and shift input.
    always_comb begin
        p_n_sign_r4: assert (flags[BIT_N] == (wide ? op_r[DATA_W-1] : op_r[NARROW_W-1]));
        if (cls == CLS_SHIFT) begin
            p_shift_v_r6: assert (flags[BIT_V] == (flags[BIT_N] ^ shift_c));
        end
    end

endmodule

// File: rtl/ccr_store.sv
// Condition code register with masked update of the N Z V C field.
// Upper four bits only ever hold their reset value.
// Synchronous active-low reset.
module ccr_store (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                upd_en,
    input  logic [ccr_pkg::NZVC_W-1:0]          flags,
    input  logic [ccr_pkg::NZVC_W-1:0]          wr_mask,
    output logic [ccr_pkg::CCR_W-1:0]           ccr_q
);
    import ccr_pkg::*;

    localparam int UPPER_W = CCR_W - NZVC_W;

    logic [CCR_W-1:0] ccr_r;
    logic [CCR_W-1:0] ccr_d;
    logic [CCR_W-1:0] full_mask;

    assign full_mask = {{UPPER_W{1'b0}}, wr_mask};

    // Merge the new flags into the bits the class may write.
    always_comb begin
        ccr_d = ccr_r;
        if (upd_en) begin
            ccr_d = (ccr_r & ~full_mask) | ({{UPPER_W{1'b0}}, flags} & full_mask);
        end
    end

    // State register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ccr_r <= CCR_RESET;
        end else begin
            ccr_r <= ccr_d;
        end
    end

    assign ccr_q = ccr_r;

    p_reset_value_r1: assert property (@(posedge clk)
        !rst_n |=> ccr_q == CCR_RESET);

    p_hold_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_en |=> $stable(ccr_q));

    p_upper_fixed_r8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ccr_q[CCR_W-1:NZVC_W] == $past(ccr_q[CCR_W-1:NZVC_W]));

    p_test_keeps_c_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && !wr_mask[BIT_C]) |=> ccr_q[BIT_C] == $past(ccr_q[BIT_C]));

endmodule

// File: rtl/ccr_flag_unit.sv
// Top level of the condition code flag unit.
// Computes N Z V C for 8- or 16-bit operations from operand and result
// sign bits and writes them into the condition code register on upd_en.
// Assumes the datapath supplies the result and the shifter carry.
module ccr_flag_unit #(
    parameter int DATA_W   = 16,
    parameter int NARROW_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        op_sel,
    input  logic              wide,
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    input  logic [DATA_W-1:0] op_r,
    input  logic              shift_c,
    input  logic              upd_en,
    output logic [3:0]        flags_nzvc,
    output logic [7:0]        ccr_q
);
    import ccr_pkg::*;

    alu_class_e        cls;
    logic [NZVC_W-1:0] new_flags;
    logic [NZVC_W-1:0] wr_mask;
    logic [CCR_W-1:0]  ccr_cur;

    assign cls = alu_class_e'(op_sel);

    ccr_width_select #(
        .DATA_W   (DATA_W),
        .NARROW_W (NARROW_W)
    ) u_select (
        .op_a    (op_a),
        .op_b    (op_b),
        .op_r    (op_r),
        .cls     (cls),
        .wide    (wide),
        .shift_c (shift_c),
        .flags   (new_flags),
        .wr_mask (wr_mask)
    );

    ccr_store u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .upd_en  (upd_en),
        .flags   (new_flags),
        .wr_mask (wr_mask),
        .ccr_q   (ccr_cur)
    );

    // Visible flags: masked-off positions show the register's current value.
    always_comb begin
        flags_nzvc = (new_flags & wr_mask) | (ccr_cur[NZVC_W-1:0] & ~wr_mask);
    end

    assign ccr_q = ccr_cur;

    p_update_lands_r7: assert property (@(posedge clk) disable iff (!rst_n)
        upd_en |=> ccr_q[NZVC_W-1:0] == $past(flags_nzvc));

endmodule

// File: tb/ccr_flag_unit_test.sv
module ccr_flag_unit_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  op_sel;
    logic        wide;
    logic [15:0] op_a, op_b, op_r;
    logic        shift_c;
    logic        upd_en;
    logic [3:0]  flags_nzvc;
    logic [7:0]  ccr_q;

    int n_checks = 0;
    int n_fail   = 0;
    logic [7:0] exp_ccr;
    bit done = 0;

    always #10 clk = ~clk;

    ccr_flag_unit uut (
        .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .wide(wide),
        .op_a(op_a), .op_b(op_b), .op_r(op_r), .shift_c(shift_c),
        .upd_en(upd_en), .flags_nzvc(flags_nzvc), .ccr_q(ccr_q)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Model of the requirements: returns {N,Z,V,C} with C from the old register for test.
    function automatic logic [3:0] model(input logic [1:0] cls, input logic w,
                                         input logic [15:0] a, input logic [15:0] b,
                                         input logic [15:0] r, input logic sc,
                                         input logic old_c);
        int top = w ? 15 : 7;
        logic n, z, v, c;
        logic [15:0] rr = w ? r : {8'h00, r[7:0]};
        logic [15:0] t1, t2;
        n = r[top];
        z = (rr == 16'h0);
        case (cls)
            2'b00: begin
                t1 = (a & b) | (b & ~r) | (a & ~r);
                t2 = (a & b & ~r) | (~a & ~b & r);
                c = t1[top]; v = t2[top];
            end
            2'b01: begin
                t1 = (~a & b) | (b & r) | (~a & r);
                t2 = (a & ~b & ~r) | (~a & b & r);
                c = t1[top]; v = t2[top];
            end
            2'b10: begin v = 1'b0; c = old_c; end
            default: begin c = sc; v = n ^ sc; end
        endcase
        return {n, z, v, c};
    endfunction

    function automatic string tag_of(input logic [1:0] cls);
        case (cls)
            2'b00:   return "R2/R4/R10";
            2'b01:   return "R3/R4/R10";
            2'b10:   return "R5/R4/R10";
            default: return "R6/R4/R10";
        endcase
    endfunction

    // Apply one operation at the falling edge, check outputs, then the register.
    task automatic do_op(input logic [1:0] cls, input logic w, input logic [15:0] a,
                         input logic [15:0] b, input logic [15:0] r, input logic sc,
                         input logic en, input string extra);
        logic [3:0] e;
        op_sel = cls; wide = w; op_a = a; op_b = b; op_r = r; shift_c = sc; upd_en = en;
        #2;
        e = model(cls, w, a, b, r, sc, exp_ccr[0]);
        chk({tag_of(cls), extra}, {12'h0, flags_nzvc}, {12'h0, e});
        if (en) exp_ccr = {exp_ccr[7:4], e};
        @(posedge clk);
        @(negedge clk);
        chk(en ? "R7 update" : "R7 hold", {8'h0, ccr_q}, {8'h0, exp_ccr});
        chk("R8 upper bits", {12'h0, ccr_q[7:4]}, {12'h0, 4'hD});
        upd_en = 1'b0;
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0011));
        rst_n = 1'b0; op_sel = 2'b00; wide = 1'b0; op_a = '0; op_b = '0; op_r = '0;
        shift_c = 1'b0; upd_en = 1'b0;
        exp_ccr = 8'hD0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 reset value", {8'h0, ccr_q}, 16'h00D0);
        rst_n = 1'b1;

        // Directed corner cases
        do_op(2'b00, 0, 16'h007F, 16'h0001, 16'h0080, 0, 1, " add8 overflow");
        do_op(2'b00, 0, 16'h00FF, 16'h0001, 16'h0000, 0, 1, " add8 wrap zero");
        do_op(2'b01, 0, 16'h0000, 16'h0001, 16'h00FF, 0, 1, " sub8 borrow");
        do_op(2'b01, 0, 16'h0080, 16'h0001, 16'h007F, 0, 1, " sub8 overflow");
        do_op(2'b00, 1, 16'h7FFF, 16'h0001, 16'h8000, 0, 1, " add16 overflow");
        do_op(2'b01, 1, 16'h8000, 16'h0001, 16'h7FFF, 0, 1, " sub16 overflow");
        do_op(2'b00, 1, 16'hFFFF, 16'h0001, 16'h0000, 0, 1, " add16 wrap");
        // C is now 1; test must keep it
        do_op(2'b10, 0, 16'h0000, 16'h0000, 16'h0000, 1, 1, " test keeps C");
        chk("R5 C kept", {15'h0, ccr_q[0]}, 16'h0001);
        do_op(2'b11, 0, 16'h0000, 16'h0000, 16'h0080, 0, 1, " shift V=N^C");
        do_op(2'b11, 1, 16'h0000, 16'h0000, 16'h4000, 1, 1, " shift16 C in");
        // R9: narrow op with junk upper bytes equals clean narrow op
        do_op(2'b00, 0, 16'hA57F, 16'h3C01, 16'hFF80, 0, 1, " R9 junk upper");
        do_op(2'b10, 0, 16'h0000, 16'h0000, 16'hFF00, 0, 1, " R9 test zero low byte");
        chk("R9 Z from low byte", {15'h0, ccr_q[2]}, 16'h0001);
        // R7: no update while disabled
        do_op(2'b01, 1, 16'h0000, 16'h0001, 16'hFFFF, 0, 0, " R7 disabled");

        // Random operations
        for (int i = 0; i < 400; i++) begin
            logic [15:0] a = 16'($urandom);
            logic [15:0] b = 16'($urandom);
            logic [1:0]  c = 2'($urandom);
            logic        w = 1'($urandom);
            logic [15:0] r;
            case (c)
                2'b00:   r = a + b;
                2'b01:   r = a - b;
                2'b10:   r = ($urandom % 8 == 0) ? 16'h0 : a;
                default: r = a << 1;
            endcase
            if (!w) r = {16'($urandom) & 16'hFF00} | (r & 16'h00FF);
            do_op(c, w, a, b, r, 1'($urandom), 1'($urandom % 4 != 0), (w ? " rand16" : " rand8 R9"));
        end

        // Mid-run reset
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        exp_ccr = 8'hD0;
        chk("R1 reset after run", {8'h0, ccr_q}, 16'h00D0);
        rst_n = 1'b1;

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule